// File: doc/BRIEF.md
# APB Seconds Counter with Alarm

This peripheral keeps elapsed time as a 32-bit count of seconds. A built-in prescaler divides the system clock and produces one tick per second. Each tick adds one to the count, and the count wraps modulo 2^32. Software reaches the block through a zero-wait-state APB slave that decodes a 4 KB window. Through it, software can:

- preset the count;
- read the count back;
- program an alarm value;
- enable or mask the single interrupt line;
- read the raw and masked alarm flags;
- acknowledge the alarm.

The counter cannot be stopped. An alarm is raised in two cases: when a tick brings the count to the alarm value, or when a write to the preset or alarm register leaves the two values equal. In the second case the alarm is raised on the same edge as the write. A fixed eight-word identification block occupies the top of the window, so that discovery software can recognise the part.

Top module: `rtc_apb_sec`

## Requirements
- R1: After a synchronous active-low reset, the count, alarm value, preset readback, mask and raw flag all read 0, and `irq` is low.
- R2: A write to word 2 (byte offset 0x08) replaces the count with the written value on the access edge. A read of word 2 returns the last value written there.
- R3: The count read at word 0 (offset 0x00) rises by exactly one every `TICK_DIV` clock cycles. The first tick falls on the `TICK_DIV`-th edge after reset is released. The count wraps from 0xFFFFFFFF to 0.
- R4: The raw flag (word 5, offset 0x14, bit 0) is set on the edge where the new count equals the new alarm value (word 1, offset 0x04). Only an edge that carries a tick, a preset write or an alarm write can set it. Comparison is modulo 2^32, so an alarm value below the count fires after wrap.
- R5: Only bit 0 of a write to word 4 (offset 0x10) is kept as the mask. Both `irq` and word 6 (offset 0x18) equal raw AND mask, and `irq` comes from a register that changes on the same edge as the raw flag.
- R6: Any write to word 7 (offset 0x1C) clears the raw flag, whatever the data. If that same edge carries a tick that makes the count equal the alarm value, the set wins and the flag stays 1.
- R7: Word 3 (offset 0x0C) always reads 1, and writes to it change nothing.
- R8: Reads of word 7 and of unmapped offsets return 0. Writes to words 0, 5 and 6 leave the count and the flags unchanged.
- R9: Offsets 0xFE0 to 0xFFC each return one byte in bits [7:0], in the order 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) / read (0) |
| paddr | input | 10 | APB word address, byte address bits [11:2] |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid during a read access |
| pready | output | 1 | Transfer done, tied high |
| pslverr | output | 1 | Transfer error, tied low |
| irq | output | 1 | Registered alarm interrupt (raw AND mask) |

## Verification
The acknowledge write and a tick that brings the count onto the alarm value can land on the same edge. The bench provokes this by tracking the prescaler phase from reset with its own cycle counter. It first presets the count one below the alarm value. It then times an acknowledge write so that its access edge is exactly the tick edge. The outcome is judged by reading the raw flag and the count after that edge: the flag must still be 1 and the count must equal the alarm value. A lone acknowledge afterwards must then clear the flag.

// File: rtl/rtc_sec_pkg.sv
// Shared constants and types for the seconds counter.
// Assumes a 32-bit APB data path and word addressing over a 4 KB window.
package rtc_sec_pkg;

    localparam int WORD_AW = 10;
    localparam int DATA_W  = 32;

    // Register select, taken from word-address bits [2:0] inside the base page.
    typedef enum logic [2:0] {
        SEL_COUNT = 3'd0,
        SEL_ALARM = 3'd1,
        SEL_PRESET = 3'd2,
        SEL_CTRL  = 3'd3,
        SEL_MASK  = 3'd4,
        SEL_RAW   = 3'd5,
        SEL_MSTAT = 3'd6,
        SEL_ACK   = 3'd7
    } reg_sel_e;

    // Word-address bits [9:3] that select the identification page (0xFE0..0xFFF).
    localparam logic [6:0] ID_PAGE = 7'h7F;

    // One-cycle write strobes handed from the decoder to the core.
    typedef struct packed {
        logic preset;
        logic alarm;
        logic mask;
        logic ack;
    } wr_strobe_t;

    // Identification byte for word index 0..7 of the ID page.
    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'h31;
            3'd1:    return 8'h10;
            3'd2:    return 8'h14;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/rtc_tick_gen.sv
// Prescaler: emits a one-cycle tick every DIV clock cycles.
// Assumes DIV >= 1; the first tick falls on the DIV-th edge after reset release.
module rtc_tick_gen #(
    parameter int unsigned DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV == 1) begin : g_every_cycle
            // Divide-by-one: every edge is a tick.
            assign tick = 1'b1;
        end else begin : g_divider
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] phase_q;

            assign tick = (phase_q == LAST);

            // Phase counter, restarts after each tick.
            always_ff @(posedge clk) begin
                if (!rst_n)    phase_q <= '0;
                else if (tick) phase_q <= '0;
                else           phase_q <= phase_q + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/rtc_apb_regs.sv
// APB decoder: turns access-phase writes into strobes and muxes read data.
// Assumes zero wait states; purely combinational, holds no state.
module rtc_apb_regs
    import rtc_sec_pkg::*;
(
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [WORD_AW-1:0] waddr,
    input  logic [DATA_W-1:0]  count_q,
    input  logic [DATA_W-1:0]  alarm_q,
    input  logic [DATA_W-1:0]  preset_q,
    input  logic               mask_q,
    input  logic               raw_q,
    output wr_strobe_t         wr,
    output logic [DATA_W-1:0]  rdata
);
    logic     in_base;
    logic     in_id;
    reg_sel_e sel;
    logic     wr_acc;

    assign in_base = (waddr[WORD_AW-1:3] == '0);
    assign in_id   = (waddr[WORD_AW-1:3] == ID_PAGE);
    assign sel     = reg_sel_e'(waddr[2:0]);
    assign wr_acc  = psel && penable && pwrite && in_base;

    // Write strobes; writes to read-only words decode to nothing.
    always_comb begin
        wr        = '0;
        wr.preset = wr_acc && (sel == SEL_PRESET);
        wr.alarm  = wr_acc && (sel == SEL_ALARM);
        wr.mask   = wr_acc && (sel == SEL_MASK);
        wr.ack    = wr_acc && (sel == SEL_ACK);
    end

    // Read mux; unmapped words and the write-only acknowledge word return 0.
    always_comb begin
        rdata = '0;
        if (psel && !pwrite) begin
            if (in_id) begin
                rdata = {{(DATA_W-8){1'b0}}, id_byte(waddr[2:0])};
            end else if (in_base) begin
                case (sel)
                    SEL_COUNT:  rdata = count_q;
                    SEL_ALARM:  rdata = alarm_q;
                    SEL_PRESET: rdata = preset_q;
                    SEL_CTRL:   rdata = {{(DATA_W-1){1'b0}}, 1'b1};
                    SEL_MASK:   rdata = {{(DATA_W-1){1'b0}}, mask_q};
                    SEL_RAW:    rdata = {{(DATA_W-1){1'b0}}, raw_q};
                    SEL_MSTAT:  rdata = {{(DATA_W-1){1'b0}}, raw_q & mask_q};
                    default:    rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/rtc_alarm_core.sv
// Seconds count, alarm value, preset readback, mask, raw flag and registered irq.
// Assumes the strobes are one-cycle pulses and that at most one is active per edge.
// The alarm compare uses next-state values, so a write that creates equality
// sets the flag on its own edge.
module rtc_alarm_core
    import rtc_sec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  wr_strobe_t        wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] count_q,
    output logic [DATA_W-1:0] alarm_q,
    output logic [DATA_W-1:0] preset_q,
    output logic              mask_q,
    output logic              raw_q,
    output logic              irq_q
);
    logic [DATA_W-1:0] count_d;
    logic [DATA_W-1:0] alarm_d;
    logic              mask_d;
    logic              raw_d;
    logic              hit;

    // Next count: a preset beats a tick; wraps modulo 2^DATA_W.
    always_comb begin
        if (wr.preset)  count_d = wdata;
        else if (tick)  count_d = count_q + 1'b1;
        else            count_d = count_q;
    end

    assign alarm_d = wr.alarm ? wdata    : alarm_q;
    assign mask_d  = wr.mask  ? wdata[0] : mask_q;
    assign hit     = (wr.preset || wr.alarm || tick) && (count_d == alarm_d);

    // Raw flag: a hit outranks an acknowledge on the same edge.
    always_comb begin
        if (hit)         raw_d = 1'b1;
        else if (wr.ack) raw_d = 1'b0;
        else             raw_d = raw_q;
    end

    // State registers, all cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q  <= '0;
            alarm_q  <= '0;
            preset_q <= '0;
            mask_q   <= 1'b0;
            raw_q    <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            count_q  <= count_d;
            alarm_q  <= alarm_d;
            if (wr.preset) preset_q <= wdata;
            mask_q   <= mask_d;
            raw_q    <= raw_d;
            irq_q    <= raw_d & mask_d;
        end
    end
endmodule

// File: rtl/rtc_apb_sec.sv
// Top: APB seconds counter with alarm interrupt.
// Assumes the APB master gives word addresses (byte bits [11:2]) and that
// TICK_DIV equals the clock frequency in Hz for a one-second tick.
module rtc_apb_sec
    import rtc_sec_pkg::*;
#(
    parameter int unsigned TICK_DIV = 32768
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [11:2] paddr,
    input  logic [31:0] pwdata,
    output logic [31:0] prdata,
    output logic        pready,
    output logic        pslverr,
    output logic        irq
);
    logic              tick;
    wr_strobe_t        wr;
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] alarm_q;
    logic [DATA_W-1:0] preset_q;
    logic              mask_q;
    logic              raw_q;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    rtc_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    rtc_apb_regs u_regs (
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .waddr    (paddr),
        .count_q  (count_q),
        .alarm_q  (alarm_q),
        .preset_q (preset_q),
        .mask_q   (mask_q),
        .raw_q    (raw_q),
        .wr       (wr),
        .rdata    (prdata)
    );

    rtc_alarm_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .wr       (wr),
        .wdata    (pwdata),
        .count_q  (count_q),
        .alarm_q  (alarm_q),
        .preset_q (preset_q),
        .mask_q   (mask_q),
        .raw_q    (raw_q),
        .irq_q    (irq)
    );
endmodule

// File: rtl/rtc_apb_sec_chk.sv
// Property checker for rtc_apb_sec, attached by bind below.
// Assumes it sees the top's ports plus its tick, count and flag nets.
module rtc_apb_sec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        psel,
    input logic        penable,
    input logic        pwrite,
    input logic [11:2] paddr,
    input logic [31:0] pwdata,
    input logic [31:0] prdata,
    input logic        irq,
    input logic        tick,
    input logic [31:0] count_q,
    input logic        mask_q,
    input logic        raw_q
);
    logic wr_any;
    assign wr_any = psel && penable && pwrite;

    p_preset_loads_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && paddr == 10'd2) |=> (count_q == $past(pwdata)));

    p_tick_steps_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(wr_any && paddr == 10'd2)) |=> (count_q == $past(count_q) + 32'd1));

    p_count_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !(wr_any && paddr == 10'd2)) |=> $stable(count_q));

    p_alarm_write_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && paddr == 10'd1 && !tick && pwdata == count_q) |=> raw_q);

    p_irq_follows_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (raw_q && mask_q));

    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && paddr == 10'd7 && !tick) |=> !raw_q);

    p_ctrl_reads_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && paddr == 10'd3) |-> (prdata == 32'd1));

    p_ack_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && paddr == 10'd7) |-> (prdata == 32'd0));
endmodule

bind rtc_apb_sec rtc_apb_sec_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .prdata  (prdata),
    .irq     (irq),
    .tick    (tick),
    .count_q (count_q),
    .mask_q  (mask_q),
    .raw_q   (raw_q)
);

// File: tb/rtc_apb_sec_tb_top.sv
// Bench for rtc_apb_sec: a vector table walked by one loop, then directed tests.
module rtc_apb_sec_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 8;

    // Word addresses.
    localparam logic [9:0] A_COUNT = 10'd0, A_ALARM = 10'd1, A_PRESET = 10'd2,
                           A_CTRL = 10'd3, A_MASK = 10'd4, A_RAW = 10'd5,
                           A_MSTAT = 10'd6, A_ACK = 10'd7;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        psel, penable, pwrite;
    logic [11:2] paddr;
    logic [31:0] pwdata, prdata;
    logic        pready, pslverr, irq;

    int n_run  = 0;
    int n_fail = 0;
    int cyc;

    rtc_apb_sec #(.TICK_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Edges since reset release; a tick falls on edges whose index is DIV-1 mod DIV.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Vector: {write, word address, write data, expected read, requirement number}.
    localparam int NV = 22;
    localparam logic [82:0] VEC [NV] = '{
        {1'b1, 10'd4,   32'hFFFF_FFFE, 32'h0, 8'd5},  // R5 mask keeps bit 0 only
        {1'b0, 10'd4,   32'h0, 32'h0000_0000, 8'd5},
        {1'b1, 10'd4,   32'h3, 32'h0, 8'd5},
        {1'b0, 10'd4,   32'h0, 32'h0000_0001, 8'd5},
        {1'b1, 10'd3,   32'h0, 32'h0, 8'd7},          // R7 control write ignored
        {1'b0, 10'd3,   32'h0, 32'h0000_0001, 8'd7},
        {1'b0, 10'd7,   32'h0, 32'h0000_0000, 8'd8},  // R8 ack word reads 0
        {1'b0, 10'd8,   32'h0, 32'h0000_0000, 8'd8},  // R8 unmapped 0x20
        {1'b0, 10'h3F7, 32'h0, 32'h0000_0000, 8'd8},  // R8 unmapped 0xFDC
        {1'b1, 10'd1,   32'h1234_5678, 32'h0, 8'd4},
        {1'b0, 10'd1,   32'h0, 32'h1234_5678, 8'd4},  // R4 alarm value readback
        {1'b1, 10'd2,   32'hA5A5_0000, 32'h0, 8'd2},
        {1'b0, 10'd2,   32'h0, 32'hA5A5_0000, 8'd2},  // R2 preset readback
        {1'b0, 10'h3F8, 32'h0, 32'h0000_0031, 8'd9},  // R9 identification bytes
        {1'b0, 10'h3F9, 32'h0, 32'h0000_0010, 8'd9},
        {1'b0, 10'h3FA, 32'h0, 32'h0000_0014, 8'd9},
        {1'b0, 10'h3FB, 32'h0, 32'h0000_0000, 8'd9},
        {1'b0, 10'h3FC, 32'h0, 32'h0000_000D, 8'd9},
        {1'b0, 10'h3FD, 32'h0, 32'h0000_00F0, 8'd9},
        {1'b0, 10'h3FE, 32'h0, 32'h0000_0005, 8'd9},
        {1'b0, 10'h3FF, 32'h0, 32'h0000_00B1, 8'd9},
        {1'b0, 10'd5,   32'h0, 32'h0000_0000, 8'd4}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    // Called at a negedge; commits on the edge after the next negedge.
    task automatic apb_wr(input logic [9:0] a, input logic [31:0] d);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [9:0] a, output logic [31:0] v);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1 v = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, a, b;
        rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0; paddr = '0; pwdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R10 handshake outputs.
        apb_rd(A_COUNT, v);  check("R1 count", v, 32'h0);
        apb_rd(A_ALARM, v);  check("R1 alarm", v, 32'h0);
        apb_rd(A_PRESET, v); check("R1 preset", v, 32'h0);
        apb_rd(A_RAW, v);    check("R1 raw", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R10 pready", {31'b0, pready}, 32'h1);
        check("R10 pslverr", {31'b0, pslverr}, 32'h0);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][82]) apb_wr(VEC[i][81:72], VEC[i][71:40]);
            else begin
                apb_rd(VEC[i][81:72], v);
                check($sformatf("R%0d vec%0d", VEC[i][7:0], i), v, VEC[i][39:8]);
            end
        end

        // R3 rate: hold a read of the count for 4*DIV cycles.
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = A_COUNT;
        @(negedge clk); penable = 1'b1;
        #1 a = prdata;
        repeat (4*DIV) @(negedge clk);
        #1 b = prdata;
        check("R3 rate", b - a, 32'd4);
        @(negedge clk); psel = 1'b0; penable = 1'b0;

        // R3 wrap from all ones to zero.
        apb_wr(A_PRESET, 32'hFFFF_FFFF);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b1; paddr = A_COUNT;
        for (int k = 0; k < 3*DIV; k++) begin
            #1 v = prdata;
            if (v != 32'hFFFF_FFFF) break;
            @(negedge clk);
        end
        check("R3 wrap", v, 32'h0);
        @(negedge clk); psel = 1'b0; penable = 1'b0;

        // R4 alarm below count fires after wrap; mask is 1 from the table.
        apb_wr(A_ACK, 32'h0);
        apb_wr(A_PRESET, 32'hFFFF_FFFE);
        apb_wr(A_ALARM, 32'h0000_0001);
        apb_rd(A_RAW, v);   check("R4 not yet", v, 32'h0);
        repeat (5*DIV) @(negedge clk);
        apb_rd(A_RAW, v);   check("R4 after wrap", v, 32'h1);
        check("R5 irq set", {31'b0, irq}, 32'h1);
        apb_rd(A_MSTAT, v); check("R5 masked status", v, 32'h1);

        // R8 writes to raw and masked status do nothing.
        apb_wr(A_RAW, 32'h0);
        apb_wr(A_MSTAT, 32'h0);
        apb_rd(A_RAW, v);   check("R8 raw kept", v, 32'h1);

        // R5 masking.
        apb_wr(A_MASK, 32'h0);
        check("R5 irq masked", {31'b0, irq}, 32'h0);
        apb_rd(A_MSTAT, v); check("R5 masked status off", v, 32'h0);
        apb_rd(A_RAW, v);   check("R5 raw unaffected", v, 32'h1);

        // R6 acknowledge with zero data clears.
        apb_wr(A_ACK, 32'h0);
        apb_rd(A_RAW, v);   check("R6 ack clears", v, 32'h0);
        apb_wr(A_MASK, 32'h1);
        check("R5 irq low after ack", {31'b0, irq}, 32'h0);

        // R4 immediate set from a preset write.
        apb_wr(A_ALARM, 32'h0000_0777);
        apb_wr(A_PRESET, 32'h0000_0777);
        check("R4 immediate irq", {31'b0, irq}, 32'h1);
        apb_rd(A_RAW, v);   check("R4 immediate raw", v, 32'h1);

        // R8 write to the count word is ignored.
        apb_wr(A_PRESET, 32'h0000_1000);
        apb_wr(A_COUNT, 32'hDEAD_0000);
        apb_rd(A_COUNT, v);
        check("R8 count write ignored", (v >= 32'h1000 && v <= 32'h1003) ? 32'h1 : v, 32'h1);

        // R6 collision: acknowledge on the tick edge that reaches the alarm.
        apb_wr(A_ACK, 32'hFFFF_FFFF);
        while (cyc % DIV != 0) @(negedge clk);
        apb_wr(A_PRESET, 32'h0000_0500);   // commits on edge index 1 mod DIV
        apb_wr(A_ALARM, 32'h0000_0501);    // commits on edge index 3 mod DIV
        @(negedge clk); @(negedge clk);
        apb_wr(A_ACK, 32'h1);              // commits on edge index 7 mod DIV: tick
        apb_rd(A_RAW, v);   check("R6 set wins", v, 32'h1);
        apb_rd(A_COUNT, v); check("R6 count at alarm", v, 32'h0000_0501);
        apb_wr(A_ACK, 32'h0);
        apb_rd(A_RAW, v);   check("R6 lone ack", v, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule